// File: doc/BRIEF.md
# Signed High-Word Multiply-Accumulate Unit

This block is a two-stage pipelined arithmetic datapath. It takes two signed 32-bit operands, forms their full 64-bit product and then does one of three things with it. It can pass the product through unchanged. It can add the product to a third 32-bit operand placed in the upper half of a 64-bit word. It can subtract the product from that placed operand. Only the upper 32 bits of the final 64-bit value leave the block. A rounding flag chooses between two ways of dropping the low word: cutting it off, or first adding half of one output unit (0x80000000) and then cutting it off.

An execution unit feeds the block one operation per cycle. Each operation arrives with an `inValid` qualifier and an `inExec` enable, and the caller has already evaluated any condition that drives `inExec`. An operation that is valid and enabled produces a result on `outResult`, with `outValid` high, exactly two cycles later. All other slots produce nothing. The block has no status flags.

Top module: `hiword_mac_unit`

## Requirements
- R1: In multiply mode (`inOp` = 2'b00) the result is bits 63:32 of the signed 64-bit product of `inA` and `inB`, both read as two's complement.
- R2: In accumulate mode (`inOp` = 2'b01) the result is bits 63:32 of ({`inC`, 32'h0} + product).
- R3: In subtract mode (`inOp` = 2'b10) the result is bits 63:32 of ({`inC`, 32'h0} − product). The operand order is third operand minus product.
- R4: When `inRound` is 1, 64'h80000000 is added to the 64-bit intermediate before bits 63:32 are taken. When `inRound` is 0, bits 31:0 are discarded.
- R5: The reserved code `inOp` = 2'b11 gives the same result as multiply mode.
- R6: All 64-bit intermediate arithmetic wraps modulo 2^64 and never saturates.
- R7: An operation that is valid and enabled at a clock edge appears with `outValid` = 1 after exactly two further edges. A new operation is accepted on every cycle.
- R8: A slot with `inValid` = 0 or `inExec` = 0 produces `outValid` = 0 two cycles later. `outResult` reads zero whenever `outValid` = 0.
- R9: A synchronous active-high `rst` clears every pipeline valid bit, so `outValid` is 0 on the cycle after any reset edge, even when operations are in flight.
- R10: (−2^31)×(−2^31) in multiply mode with truncation gives 0x40000000. A product of −1 gives 0x00000000 with rounding and 0xFFFFFFFF with truncation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operation present this cycle |
| inExec | input | 1 | Execute enable for this operation |
| inOp | input | 2 | Mode: 00 multiply, 01 accumulate, 10 subtract, 11 as multiply |
| inRound | input | 1 | 1 = round, 0 = truncate |
| inA | input | 32 | Signed multiplicand |
| inB | input | 32 | Signed multiplier |
| inC | input | 32 | Third operand, placed in the upper half |
| outValid | output | 1 | Result present |
| outResult | output | 32 | High word of the result; zero when no result is present |

## Verification
Most internal faults show up at the ports within two cycles. A stuck or misrouted mode decode, a lost sign extension or a swapped subtract order gives a wrong `outResult` on the same slot that carried the offending operation. The operand patterns are picked so that each of these faults changes at least one bit of the high word. A stale valid bit in either stage shows as an `outValid` pulse or a missing pulse exactly two cycles after the slot that caused it. A reset that fails to clear the pipeline shows on the cycle right after the reset edge.

// File: rtl/hwm_pkg.sv
package hwm_pkg;

  typedef enum logic [1:0] {
    OP_MUL = 2'b00,
    OP_ACC = 2'b01,
    OP_SUB = 2'b10,
    OP_RSV = 2'b11
  } hwmOp_e;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic s1Load;   // capture product and third operand
    logic s2Load;   // capture high-word result
    logic s2Add;    // stage 2 adds product to shifted operand
    logic s2Sub;    // stage 2 subtracts product from shifted operand
    logic s2Round;  // stage 2 adds half an output unit
  } hwmCtl_t;

endpackage

// File: rtl/hwm_ctrl.sv
module hwm_ctrl
  import hwm_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inValid,
  input  logic       inExec,
  input  logic [1:0] inOp,
  input  logic       inRound,
  output hwmCtl_t    ctl,
  output logic       outValid
);

  logic   fire;
  logic   v1Q, v2Q;
  hwmOp_e op1Q;
  logic   rnd1Q;

  assign fire = inValid & inExec;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1Q <= 1'b0;
      v2Q <= 1'b0;
    end else begin
      v1Q <= fire;
      v2Q <= v1Q;
    end
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      op1Q  <= hwmOp_e'(inOp);
      rnd1Q <= inRound;
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.s1Load  = fire;
    ctl.s2Load  = v1Q;
    ctl.s2Round = rnd1Q;
    unique case (op1Q)
      OP_ACC:  ctl.s2Add = 1'b1;
      OP_SUB:  ctl.s2Sub = 1'b1;
      default: ;  // multiply and reserved code
    endcase
  end

  assign outValid = v2Q;

endmodule

// File: rtl/hwm_datapath.sv
module hwm_datapath
  import hwm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  hwmCtl_t           ctl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] opC,
  output logic [DATA_W-1:0] resHi
);

  localparam int PROD_W = 2 * DATA_W;
  localparam logic [PROD_W-1:0] RND_K = PROD_W'(1) << (DATA_W - 1);

  logic [PROD_W-1:0] extA, extB, prodComb;
  logic [PROD_W-1:0] prodQ;
  logic [DATA_W-1:0] opCQ;
  logic [PROD_W-1:0] shifted, combined, rounded;
  logic [DATA_W-1:0] resQ;

  // Stage 1: sign-extend and multiply; the low 2W bits equal the signed product
  assign extA     = {{DATA_W{opA[DATA_W-1]}}, opA};
  assign extB     = {{DATA_W{opB[DATA_W-1]}}, opB};
  assign prodComb = extA * extB;

  always_ff @(posedge clk) begin
    if (ctl.s1Load) begin
      prodQ <= prodComb;
      opCQ  <= opC;
    end
  end

  // Stage 2: combine, round, take high word
  assign shifted = {opCQ, {DATA_W{1'b0}}};

  always_comb begin
    if (ctl.s2Sub)      combined = shifted - prodQ;
    else if (ctl.s2Add) combined = shifted + prodQ;
    else                combined = prodQ;
    rounded = combined + (ctl.s2Round ? RND_K : '0);
  end

  always_ff @(posedge clk) begin
    if (ctl.s2Load) resQ <= rounded[PROD_W-1:DATA_W];
  end

  assign resHi = resQ;

endmodule

// File: rtl/hiword_mac_unit.sv
module hiword_mac_unit
  import hwm_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic              inExec,
  input  logic [1:0]        inOp,
  input  logic              inRound,
  input  logic [DATA_W-1:0] inA,
  input  logic [DATA_W-1:0] inB,
  input  logic [DATA_W-1:0] inC,
  output logic              outValid,
  output logic [DATA_W-1:0] outResult
);

  hwmCtl_t           ctl;
  logic [DATA_W-1:0] resHi;

  hwm_ctrl ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inExec   (inExec),
    .inOp     (inOp),
    .inRound  (inRound),
    .ctl      (ctl),
    .outValid (outValid)
  );

  hwm_datapath #(.DATA_W(DATA_W)) dp_i (
    .clk   (clk),
    .ctl   (ctl),
    .opA   (inA),
    .opB   (inB),
    .opC   (inC),
    .resHi (resHi)
  );

  assign outResult = outValid ? resHi : '0;

endmodule

// File: rtl/hwm_checker.sv
module hwm_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic              inExec,
  input logic [1:0]        inOp,
  input logic              inRound,
  input logic [DATA_W-1:0] inA,
  input logic [DATA_W-1:0] inB,
  input logic [DATA_W-1:0] inC,
  input logic              outValid,
  input logic [DATA_W-1:0] outResult
);

  logic [1:0] sinceRst;

  always_ff @(posedge clk) begin
    if (rst)                sinceRst <= 2'd0;
    else if (sinceRst != 2'd2) sinceRst <= sinceRst + 2'd1;
  end

  function automatic logic [DATA_W-1:0] mulHi(input logic signed [DATA_W-1:0] a,
                                              input logic signed [DATA_W-1:0] b);
    logic signed [2*DATA_W-1:0] p;
    p = a * b;
    return p[2*DATA_W-1:DATA_W];
  endfunction

  // R7: fixed two-cycle latency
  p_latency_r7: assert property (@(posedge clk) disable iff (rst)
    (sinceRst == 2'd2) |-> (outValid == $past(inValid && inExec, 2)));

  // R8: no result presented without valid
  p_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> (outResult == '0));

  // R9: reset empties the pipeline
  p_reset_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !outValid);

  // R1: truncated multiply returns product high word
  p_mul_hi_r1: assert property (@(posedge clk) disable iff (rst)
    (sinceRst == 2'd2 && $past(inValid && inExec, 2) && $past(inOp, 2) == 2'b00
     && !$past(inRound, 2))
    |-> (outResult == mulHi($past(inA, 2), $past(inB, 2))));

endmodule

bind hiword_mac_unit hwm_checker #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/hiword_mac_unit_tb.sv
module hiword_mac_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 16;

  logic        clk = 1'b0;
  logic        rst;
  logic        inValid, inExec, inRound;
  logic [1:0]  inOp;
  logic [31:0] inA, inB, inC;
  logic        outValid;
  logic [31:0] outResult;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hiword_mac_unit dut_i (
    .clk(clk), .rst(rst), .inValid(inValid), .inExec(inExec), .inOp(inOp),
    .inRound(inRound), .inA(inA), .inB(inB), .inC(inC),
    .outValid(outValid), .outResult(outResult)
  );

  // {op, round, a, b, c, expected}
  localparam logic [130:0] VECS [0:NV-1] = '{
    {2'b00, 1'b0, 32'h00000003, 32'h00000005, 32'h00000000, 32'h00000000}, // R1 small
    {2'b00, 1'b0, 32'h40000000, 32'h00000004, 32'h00000000, 32'h00000001}, // R1
    {2'b00, 1'b0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 32'hFFFFFFFF}, // R10 trunc -1
    {2'b00, 1'b1, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 32'h00000000}, // R10 round -1
    {2'b00, 1'b0, 32'h80000000, 32'h80000000, 32'h00000000, 32'h40000000}, // R10 min*min
    {2'b01, 1'b0, 32'h00010000, 32'h00010000, 32'h0000000A, 32'h0000000B}, // R2
    {2'b10, 1'b0, 32'h00010000, 32'h00010000, 32'h0000000A, 32'h00000009}, // R3
    {2'b10, 1'b0, 32'h00000001, 32'h00000001, 32'h00000000, 32'hFFFFFFFF}, // R3 trunc
    {2'b10, 1'b1, 32'h00000001, 32'h00000001, 32'h00000000, 32'h00000000}, // R4 round
    {2'b01, 1'b1, 32'h00008000, 32'h00010000, 32'h00000005, 32'h00000006}, // R4 carry in
    {2'b01, 1'b0, 32'h00008000, 32'h00010000, 32'h00000005, 32'h00000005}, // R4 trunc
    {2'b11, 1'b0, 32'h40000000, 32'h00000004, 32'h00000063, 32'h00000001}, // R5 reserved
    {2'b10, 1'b0, 32'hFFFF0000, 32'h00010000, 32'h00000003, 32'h00000004}, // R3 order
    {2'b01, 1'b0, 32'h00010000, 32'h00010000, 32'h7FFFFFFF, 32'h80000000}, // R6 wrap
    {2'b00, 1'b1, 32'h7FFFFFFF, 32'h00000001, 32'h00000000, 32'h00000000}, // R4 just below
    {2'b00, 1'b0, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'h00000000, 32'h3FFFFFFF}  // R1 max*max
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic idle();
    inValid = 1'b0; inExec = 1'b0; inOp = 2'b00; inRound = 1'b0;
    inA = '0; inB = '0; inC = '0;
  endtask

  task automatic drive(input logic [130:0] v, input logic ex);
    inValid = 1'b1; inExec = ex;
    {inOp, inRound, inA, inB, inC} = v[130:32];
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 reset valid", {31'b0, outValid}, 32'h0);
    check("R8 reset result", outResult, 32'h0);
    rst = 1'b0;

    // Back-to-back stream: R7 one per cycle, latency two
    for (int j = 0; j < NV + 2; j++) begin
      @(negedge clk);
      if (j >= 2) begin
        check("R7 valid", {31'b0, outValid}, 32'h1);
        check($sformatf("vector %0d R1-model", j - 2), outResult, VECS[j-2][31:0]);
      end
      if (j < NV) drive(VECS[j], 1'b1);
      else idle();
    end
    @(negedge clk);
    check("R8 idle valid", {31'b0, outValid}, 32'h0);

    // R8: exec low suppresses the slot
    drive(VECS[1], 1'b0);
    @(negedge clk); idle();
    @(negedge clk);
    check("R8 exec low valid", {31'b0, outValid}, 32'h0);
    check("R8 exec low result", outResult, 32'h0);

    // R8: valid low with exec high
    drive(VECS[1], 1'b1); inValid = 1'b0;
    @(negedge clk); idle();
    @(negedge clk);
    check("R8 valid low", {31'b0, outValid}, 32'h0);

    // R9: reset with an operation in flight
    @(negedge clk);
    drive(VECS[1], 1'b1);
    @(negedge clk); idle(); rst = 1'b1;
    @(negedge clk);
    check("R9 flush valid", {31'b0, outValid}, 32'h0);
    check("R9 flush result", outResult, 32'h0);
    rst = 1'b0;

    // R7: operation after reset still works
    drive(VECS[4], 1'b1);
    @(negedge clk); idle();
    @(negedge clk);
    check("R7 post reset valid", {31'b0, outValid}, 32'h1);
    check("R10 post reset", outResult, 32'h40000000);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule